// File: doc/BRIEF.md
# FIFO Interrupt Status and Clear Unit

This block sits beside the transmit and receive FIFOs of a serial controller. It watches the FIFO fill levels and the strobes that access them, and turns them into a seven-bit raw interrupt vector. Two of the bits follow the levels: transmit low-water and receive threshold. Four bits are sticky error or event flags: transmit overflow, receive underflow, receive overflow and chip-select release.

A mask register gates the raw vector into a masked vector. The OR of the masked vector drives a single interrupt line. A clear strobe with a four-bit data word removes sticky flags one at a time or all together. A separate six-bit status word reports busy, the FIFO full and empty conditions, and target-side transmit activity. The FIFO storage itself and the bus decoding live outside the block. The block only sees levels and strobes.

Top module: `fifo_irq_unit`

## Requirements
- R1: Raw bit 0 (transmit low-water) is 1 on the clock after an edge at which the controller was enabled and tx_level was at or below the held transmit threshold; otherwise it is 0.
- R2: Raw bit 4 (receive threshold) is 1 on the clock after an enabled edge at which rx_level was strictly greater than the held receive threshold, that is, once threshold+1 entries are present.
- R3: Both thresholds are captured from their inputs only at edges where ctrl_en is 0. Changes to the threshold inputs while the block is enabled have no effect on bits 0 and 4.
- R4: While ctrl_en is 0, raw bits 0 and 4 read 0 from the following clock onward.
- R5: A tx_push while tx_level equals DEPTH sets raw bit 1 (transmit overflow). The bit stays set until it is cleared.
- R6: An rx_pop while rx_level is 0 sets raw bit 2 (receive underflow). An rx_push while rx_level equals DEPTH sets raw bit 3 (receive overflow). Both bits are sticky.
- R7: A clear strobe acts on the flags as follows. Data bit 1 clears raw bit 2, data bit 2 clears raw bit 3 and data bit 3 clears raw bit 1. Data bit 0 clears all sticky bits (1, 2, 3 and 6).
- R8: When a setting event and a clear of the same flag fall on the same edge, the flag ends up set.
- R9: A cs_release pulse sets raw bit 6. Only clear data bit 0 removes it.
- R10: masked_stat equals raw_stat AND the mask register. The mask register is loaded from mask_wdata on mask_wr and resets to 0. Raw bit 5 always reads 0.
- R11: irq is 1 exactly when masked_stat is nonzero.
- R12: status_word holds bit 0 shift_busy, bit 1 tx_level==DEPTH, bit 2 tx_level==0, bit 3 rx_level==0, bit 4 rx_level==DEPTH and bit 5 tgt_tx_busy.
- R13: After reset, raw_stat, masked_stat and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | Controller enable |
| tx_level | input | LVW | Transmit FIFO fill level |
| rx_level | input | LVW | Receive FIFO fill level |
| tx_thresh | input | LVW | Transmit low-water threshold |
| rx_thresh | input | LVW | Receive threshold |
| tx_push | input | 1 | Write strobe into the transmit FIFO |
| rx_push | input | 1 | Shifter write strobe into the receive FIFO |
| rx_pop | input | 1 | Read strobe from the receive FIFO |
| cs_release | input | 1 | Pulse when chip select goes inactive |
| shift_busy | input | 1 | Shifter busy |
| tgt_tx_busy | input | 1 | Target-side transmit busy |
| mask_wr | input | 1 | Load strobe for the mask register |
| mask_wdata | input | 7 | New mask value |
| clr_wr | input | 1 | Clear strobe |
| clr_wdata | input | 4 | Clear selection bits |
| raw_stat | output | 7 | Raw interrupt vector |
| masked_stat | output | 7 | Raw vector gated by the mask |
| irq | output | 1 | Interrupt line |
| status_word | output | 6 | Status bits |

## Verification
The bench builds the unit with DEPTH=8, so LVW is 4. With that depth, a full FIFO, a threshold of threshold+1 entries and the full/empty status bits are all reached by driving a handful of level values. Because the levels are driven directly rather than produced by a real FIFO, the bench can place a push at full, a pop at empty and a set/clear collision on exactly the edge it chooses. It can also change the thresholds mid-run, while enabled, to show that the held values are used.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int RAW_W  = 7;
  localparam int CLR_W  = 4;
  localparam int STAT_W = 6;

  // raw / mask vector positions
  localparam int B_TXLOW = 0;
  localparam int B_TXOVF = 1;
  localparam int B_RXUNF = 2;
  localparam int B_RXOVF = 3;
  localparam int B_RXHIT = 4;
  localparam int B_SPARE = 5;
  localparam int B_CSOFF = 6;

  // clear word positions
  localparam int C_ALL   = 0;
  localparam int C_RXUNF = 1;
  localparam int C_RXOVF = 2;
  localparam int C_TXOVF = 3;

  // status word positions
  localparam int S_BUSY    = 0;
  localparam int S_TXFULL  = 1;
  localparam int S_TXEMPTY = 2;
  localparam int S_RXEMPTY = 3;
  localparam int S_RXFULL  = 4;
  localparam int S_TGTBUSY = 5;

  localparam int NSTICKY = 4;

  // sticky cell index -> raw vector position
  function automatic int sticky_raw_pos(input int i);
    case (i)
      0:       return B_TXOVF;
      1:       return B_RXUNF;
      2:       return B_RXOVF;
      default: return B_CSOFF;
    endcase
  endfunction

  // sticky cell index -> own clear bit, -1 when only clear-all applies
  function automatic int sticky_clr_pos(input int i);
    case (i)
      0:       return C_TXOVF;
      1:       return C_RXUNF;
      2:       return C_RXOVF;
      default: return -1;
    endcase
  endfunction

  function automatic logic level_at_or_below(input logic [15:0] lvl, input logic [15:0] thr);
    return lvl <= thr;
  endfunction

  function automatic logic level_above(input logic [15:0] lvl, input logic [15:0] thr);
    return lvl > thr;
  endfunction
endpackage

// File: rtl/fifo_irq_level.sv
module fifo_irq_level
  import fifo_irq_pkg::*;
#(
  parameter int LVW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctrl_en,
  input  logic [LVW-1:0] tx_level,
  input  logic [LVW-1:0] rx_level,
  input  logic [LVW-1:0] tx_thr_in,
  input  logic [LVW-1:0] rx_thr_in,
  output logic           tx_low_q,
  output logic           rx_hit_q
);
  logic [LVW-1:0] tx_thr_q;
  logic [LVW-1:0] rx_thr_q;
  logic           thr_load;
  logic           tx_low_d;
  logic           rx_hit_d;

  assign thr_load = !ctrl_en;
  assign tx_low_d = ctrl_en && level_at_or_below(16'(tx_level), 16'(tx_thr_q));
  assign rx_hit_d = ctrl_en && level_above(16'(rx_level), 16'(rx_thr_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr_q <= '0;
      rx_thr_q <= '0;
      tx_low_q <= 1'b0;
      rx_hit_q <= 1'b0;
    end else begin
      if (thr_load) begin
        tx_thr_q <= tx_thr_in;
        rx_thr_q <= rx_thr_in;
      end
      tx_low_q <= tx_low_d;
      rx_hit_q <= rx_hit_d;
    end
  end

  AST_THRESH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_en |=> ($stable(tx_thr_q) && $stable(rx_thr_q))); // R3
  AST_LEVEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> (!tx_low_q && !rx_hit_q)); // R4
endmodule

// File: rtl/fifo_irq_sticky.sv
module fifo_irq_sticky
  import fifo_irq_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_own_vec,
  input  logic         clr_all,
  output logic [N-1:0] flags_q
);
  for (genvar i = 0; i < N; i++) begin : g_cell
    logic clr_hit;
    assign clr_hit = clr_all || clr_own_vec[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags_q[i] <= 1'b0;
      else if (set_vec[i]) flags_q[i] <= 1'b1;
      else if (clr_hit)    flags_q[i] <= 1'b0;
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[i] && !clr_hit) |=> flags_q[i]); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flags_q[i]); // R8
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && !set_vec[i]) |=> !flags_q[i]); // R7
  end
endmodule

// File: rtl/fifo_irq_status.sv
module fifo_irq_status
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LVW   = 6
) (
  input  logic              shift_busy,
  input  logic              tgt_tx_busy,
  input  logic [LVW-1:0]    tx_level,
  input  logic [LVW-1:0]    rx_level,
  output logic [STAT_W-1:0] status_word
);
  localparam logic [LVW-1:0] FULL_LVL = LVW'(DEPTH);

  always_comb begin
    status_word            = '0;
    status_word[S_BUSY]    = shift_busy;
    status_word[S_TXFULL]  = (tx_level == FULL_LVL);
    status_word[S_TXEMPTY] = (tx_level == '0);
    status_word[S_RXEMPTY] = (rx_level == '0);
    status_word[S_RXFULL]  = (rx_level == FULL_LVL);
    status_word[S_TGTBUSY] = tgt_tx_busy;
  end
endmodule

// File: rtl/fifo_irq_unit.sv
module fifo_irq_unit
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LVW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_en,
  input  logic [LVW-1:0]    tx_level,
  input  logic [LVW-1:0]    rx_level,
  input  logic [LVW-1:0]    tx_thresh,
  input  logic [LVW-1:0]    rx_thresh,
  input  logic              tx_push,
  input  logic              rx_push,
  input  logic              rx_pop,
  input  logic              cs_release,
  input  logic              shift_busy,
  input  logic              tgt_tx_busy,
  input  logic              mask_wr,
  input  logic [RAW_W-1:0]  mask_wdata,
  input  logic              clr_wr,
  input  logic [CLR_W-1:0]  clr_wdata,
  output logic [RAW_W-1:0]  raw_stat,
  output logic [RAW_W-1:0]  masked_stat,
  output logic              irq,
  output logic [STAT_W-1:0] status_word
);
  localparam logic [LVW-1:0] FULL_LVL = LVW'(DEPTH);

  // named internal events
  logic               tx_ovf_evt;
  logic               rx_unf_evt;
  logic               rx_ovf_evt;
  logic [CLR_W-1:0]   clr_bits;
  logic [NSTICKY-1:0] set_vec;
  logic [NSTICKY-1:0] clr_own_vec;
  logic [NSTICKY-1:0] sticky_q;
  logic               tx_low_q;
  logic               rx_hit_q;
  logic [RAW_W-1:0]   mask_q;

  assign tx_ovf_evt = tx_push && (tx_level == FULL_LVL);
  assign rx_unf_evt = rx_pop  && (rx_level == '0);
  assign rx_ovf_evt = rx_push && (rx_level == FULL_LVL);
  assign clr_bits   = clr_wr ? clr_wdata : '0;

  assign set_vec = {cs_release, rx_ovf_evt, rx_unf_evt, tx_ovf_evt};

  for (genvar i = 0; i < NSTICKY; i++) begin : g_clr_map
    if (sticky_clr_pos(i) >= 0) begin : g_own
      assign clr_own_vec[i] = clr_bits[sticky_clr_pos(i)];
    end else begin : g_none
      assign clr_own_vec[i] = 1'b0;
    end
  end

  fifo_irq_level #(.LVW(LVW)) u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_en  (ctrl_en),
    .tx_level (tx_level),
    .rx_level (rx_level),
    .tx_thr_in(tx_thresh),
    .rx_thr_in(rx_thresh),
    .tx_low_q (tx_low_q),
    .rx_hit_q (rx_hit_q)
  );

  fifo_irq_sticky #(.N(NSTICKY)) u_sticky (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (set_vec),
    .clr_own_vec(clr_own_vec),
    .clr_all    (clr_bits[C_ALL]),
    .flags_q    (sticky_q)
  );

  fifo_irq_status #(.DEPTH(DEPTH), .LVW(LVW)) u_status (
    .shift_busy (shift_busy),
    .tgt_tx_busy(tgt_tx_busy),
    .tx_level   (tx_level),
    .rx_level   (rx_level),
    .status_word(status_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= mask_wdata;
  end

  always_comb begin
    raw_stat          = '0;
    raw_stat[B_TXLOW] = tx_low_q;
    raw_stat[B_RXHIT] = rx_hit_q;
    raw_stat[B_SPARE] = 1'b0;
    for (int i = 0; i < NSTICKY; i++) begin
      raw_stat[sticky_raw_pos(i)] = sticky_q[i];
    end
  end

  assign masked_stat = raw_stat & mask_q;
  assign irq         = |masked_stat;

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0)); // R11
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(mask_wdata))); // R10
endmodule

// File: tb/fifo_irq_unit_bench.sv
module fifo_irq_unit_bench;
  localparam int DEPTH = 8;
  localparam int LVW   = 4;

  typedef struct {
    logic [6:0] raw;
    logic [6:0] msk;
    logic       irq;
    logic [5:0] st;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_en = 0, tx_push = 0, rx_push = 0, rx_pop = 0, cs_release = 0;
  logic shift_busy = 0, tgt_tx_busy = 0, mask_wr = 0, clr_wr = 0;
  logic [LVW-1:0] tx_level = 0, rx_level = 0, tx_thresh = 0, rx_thresh = 0;
  logic [6:0] mask_wdata = 0;
  logic [3:0] clr_wdata = 0;
  logic [6:0] raw_stat, masked_stat;
  logic       irq;
  logic [5:0] status_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  exp_t q[$];

  // bench model state
  logic [LVW-1:0] m_thr_tx = 0, m_thr_rx = 0;
  logic m_low = 0, m_hit = 0, m_txovf = 0, m_rxunf = 0, m_rxovf = 0, m_cs = 0;
  logic [6:0] m_mask = 0;

  always #2 clk = ~clk;  // 250 MHz

  fifo_irq_unit #(.DEPTH(DEPTH)) u_fifo_irq_unit (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
    .tx_push(tx_push), .rx_push(rx_push), .rx_pop(rx_pop),
    .cs_release(cs_release), .shift_busy(shift_busy), .tgt_tx_busy(tgt_tx_busy),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .clr_wr(clr_wr), .clr_wdata(clr_wdata),
    .raw_stat(raw_stat), .masked_stat(masked_stat), .irq(irq),
    .status_word(status_word)
  );

  // driver: model the edge, queue the expectation, step one cycle
  task automatic cyc(input string tag);
    exp_t e;
    logic all_c;
    all_c = clr_wr && clr_wdata[0];
    m_low = ctrl_en && (tx_level <= m_thr_tx);
    m_hit = ctrl_en && (rx_level > m_thr_rx);
    if (!ctrl_en) begin
      m_thr_tx = tx_thresh;
      m_thr_rx = rx_thresh;
    end
    m_txovf = (tx_push && tx_level == DEPTH) || (m_txovf && !(all_c || (clr_wr && clr_wdata[3])));
    m_rxunf = (rx_pop && rx_level == 0)      || (m_rxunf && !(all_c || (clr_wr && clr_wdata[1])));
    m_rxovf = (rx_push && rx_level == DEPTH) || (m_rxovf && !(all_c || (clr_wr && clr_wdata[2])));
    m_cs    = cs_release || (m_cs && !all_c);
    if (mask_wr) m_mask = mask_wdata;
    e.raw = {m_cs, 1'b0, m_hit, m_rxovf, m_rxunf, m_txovf, m_low};
    e.msk = e.raw & m_mask;
    e.irq = |e.msk;
    e.st  = {tgt_tx_busy, rx_level == DEPTH, rx_level == 0, tx_level == 0,
             tx_level == DEPTH, shift_busy};
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    tx_push = 0; rx_push = 0; rx_pop = 0; cs_release = 0; mask_wr = 0; clr_wr = 0;
  endtask

  // monitor: compare after each active edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (raw_stat !== e.raw || masked_stat !== e.msk || irq !== e.irq || status_word !== e.st) begin
        fails++;
        $display("FAIL %s: raw=%h msk=%h irq=%b st=%h expected raw=%h msk=%h irq=%b st=%h",
                 e.tag, raw_stat, masked_stat, irq, status_word, e.raw, e.msk, e.irq, e.st);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc("R13 reset state");
    // R3: capture thresholds while disabled
    tx_thresh = 2; rx_thresh = 3;
    cyc("R3 capture");
    ctrl_en = 1; tx_thresh = 7; rx_thresh = 0; tx_level = 3; rx_level = 1;
    cyc("R3 ignore while enabled");
    cyc("R3 ignore while enabled");
    tx_level = 2;
    cyc("R1 at threshold");
    tx_level = 0;
    cyc("R1 empty");
    rx_level = 3;
    cyc("R2 equal not above");
    rx_level = 4;
    cyc("R2 threshold plus one");
    ctrl_en = 0;
    cyc("R4 disabled");
    ctrl_en = 1; mask_wr = 1; mask_wdata = 7'h7F;
    cyc("R10 mask all");
    cyc("R11 irq high");
    tx_level = 8; tx_push = 1;
    cyc("R5 push at full");
    tx_level = 7;
    cyc("R5 sticky holds");
    rx_level = 0; rx_pop = 1;
    cyc("R6 pop at empty");
    rx_level = 8; rx_push = 1;
    cyc("R6 push at full rx");
    rx_level = 5;
    clr_wr = 1; clr_wdata = 4'b0010;
    cyc("R7 clear underflow only");
    clr_wr = 1; clr_wdata = 4'b0100;
    cyc("R7 clear rx overflow only");
    tx_level = 8; tx_push = 1; clr_wr = 1; clr_wdata = 4'b1000;
    cyc("R8 set beats clear");
    tx_level = 3; clr_wr = 1; clr_wdata = 4'b1000;
    cyc("R7 clear tx overflow");
    cs_release = 1;
    cyc("R9 cs release");
    clr_wr = 1; clr_wdata = 4'b1110;
    cyc("R9 survives own clears");
    rx_level = 0; rx_pop = 1;
    cyc("R6 underflow again");
    clr_wr = 1; clr_wdata = 4'b0001;
    cyc("R7 clear all");
    tx_level = 5; rx_level = 2;
    mask_wr = 1; mask_wdata = 7'h40;
    cyc("R10 masked out");
    cyc("R11 irq low");
    shift_busy = 1; tgt_tx_busy = 1; tx_level = 8; rx_level = 8;
    cyc("R12 status full");
    shift_busy = 0; tx_level = 0; rx_level = 0;
    cyc("R12 status empty");
    mask_wr = 1; mask_wdata = 7'h21; tx_level = 1;
    cyc("R10 spare bit reads zero");
    ctrl_en = 0;
    cyc("R4 disable again");
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule